// File: doc/BRIEF.md
# Video Sync Reference Output Generator

This block derives horizontal and vertical reference strobes from a line-locked pixel clock for the output side of a video decoder. A pixel counter runs across each line and a line counter runs across each field. From them the block builds two square-wave clock references, an active-line strobe, a horizontal sync pulse with programmable edges, a vertical gate with programmable start and stop lines, a vertical sync window and a field identifier. Lock and colour-detect results produced elsewhere arrive as plain inputs.

One status pin carries a single signal picked by a 4-bit code, optionally inverted. The pin has its own output-enable, so it can be released to high impedance. Every configuration input is captured into a shadow copy at the edge where the pixel counter wraps. Settings therefore change only on line boundaries, and no strobe is cut short inside a line.

The active-line strobe comes from a two-state machine. `ST_BLANK` moves to `ST_ACTIVE` on the transition *open* when the pixel count reaches `ACT_BEGIN-1`. `ST_ACTIVE` moves back to `ST_BLANK` on the transition *close* when the count reaches `ACT_BEGIN+ACT_PIX-1`. Otherwise each state holds. The parameters must satisfy `ACT_BEGIN >= 1` and `ACT_BEGIN+ACT_PIX <= LINE_PIX`.

Top module: `vid_sync_ref`

## Requirements
- R1: While reset is held, `rts_oe`, `rts_o`, `href_o`, `hs_o` and `fid_o` are 0. After release, the pixel count p is 1 at the first edge and counts 0..LINE_PIX-1. The line count v counts 0..FIELD_LINES-1. All shadow settings start at zero.
- R2: Select code 0 drives `rts_oe`=0 and `rts_o`=0, whatever the polarity bit is.
- R3: Select codes 1, 7, 11 and 14 drive a constant 0 before inversion, with `rts_oe`=1.
- R4: Code 2 gives a reference that toggles on every clock and is 0 at reset. Code 3 gives a reference that toggles every second clock.
- R5: Code 4 gives `lock_h`. Code 5 gives `lock_h & lock_v`. Code 6 gives `lock_h & lock_v & color_det`. These inputs reach the pin with no register delay.
- R6: The active-line strobe (`href_o`, code 8) is 1 exactly when ACT_BEGIN <= p < ACT_BEGIN+ACT_PIX. That is ACT_PIX cycles per line, on every line including vertical blanking.
- R7: Horizontal sync (`hs_o`, code 9) has begin B = 8*`cfg_hbeg` + 2*`cfg_hfine` and end E = 8*`cfg_hend` + 2*`cfg_hfine`. It is 1 for B <= p < E when B < E, for p >= B or p < E when B > E, and never when B = E.
- R8: The vertical gate (code 13) is 1 for S <= v' < T when S < T, for v' >= S or v' < T when S > T, and never when S = T. Here S = `cfg_vbeg` and T = `cfg_vend`. With `cfg_vmid`=0, v' equals v.
- R9: With `cfg_vmid`=1, v' is the previous line number (wrapping to FIELD_LINES-1) while p < LINE_PIX/2. The gate thus switches at mid-line.
- R10: Code 10 gives the active-line strobe ANDed with the vertical gate.
- R11: Vertical sync (`vs_o`, code 12) is 1 while v < VS_LINES.
- R12: The field identifier (`fid_o`, code 15) equals the field-count parity XOR (v < `cfg_vbeg`). The parity flips when v wraps to 0, so the identifier changes at the start of line `cfg_vbeg`.
- R13: With `rts_oe`=1, `rts_o` is the selected signal XOR `cfg_pol`.
- R14: Configuration inputs changed during a line have no effect until the edge at which p wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | line-locked pixel clock |
| rst | input | 1 | asynchronous reset, active high |
| cfg_sel | input | 4 | status pin source code |
| cfg_pol | input | 1 | status pin inversion |
| cfg_hbeg | input | 8 | horizontal sync begin, 8-clock units |
| cfg_hend | input | 8 | horizontal sync end, 8-clock units |
| cfg_hfine | input | 2 | horizontal sync shift, 2-clock units |
| cfg_vbeg | input | 9 | vertical gate start line, field identifier line |
| cfg_vend | input | 9 | vertical gate stop line |
| cfg_vmid | input | 1 | vertical gate switches at mid-line |
| lock_h | input | 1 | horizontal lock flag |
| lock_v | input | 1 | vertical lock flag |
| color_det | input | 1 | colour detected flag |
| rts_o | output | 1 | status pin value |
| rts_oe | output | 1 | status pin output enable |
| href_o | output | 1 | active-line strobe |
| hs_o | output | 1 | horizontal sync |
| vs_o | output | 1 | vertical sync |
| fid_o | output | 1 | field identifier |

## Verification
The bench targets four groups of corner cases.

- **Horizontal sync wrap and empty pulse.** It sweeps begin/end pairs where the begin is greater than the end and where the two are equal. A design that compared only in one direction would lose the pulse that wraps around the line end. A design that treated equal values as a full line would hold sync high throughout.
- **Vertical gate at field wrap.** It sweeps start/stop pairs around the field wrap, with and without the mid-line option. An off-by-one on the previous-line lookup would move the gate edge by a whole line or put it at the wrong half of the line.
- **Field identifier at field boundaries.** It checks the identifier across two fields with start lines of 0, inside the field and beyond the field. A design keyed to the wrong line would flip the identifier early or late.
- **Mid-line setting changes.** It changes settings partway through a line and checks that the old behaviour holds until the wrap. A design that used the live inputs would change the pin mid-line.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    typedef enum logic [3:0] {
        PIN_HIZ    = 4'd0,
        PIN_LOW    = 4'd1,
        PIN_TOG1   = 4'd2,
        PIN_TOG2   = 4'd3,
        PIN_HLOCK  = 4'd4,
        PIN_HVLOCK = 4'd5,
        PIN_ALLOK  = 4'd6,
        PIN_RSV7   = 4'd7,
        PIN_HREF   = 4'd8,
        PIN_HSYNC  = 4'd9,
        PIN_GATED  = 4'd10,
        PIN_RSV11  = 4'd11,
        PIN_VSYNC  = 4'd12,
        PIN_VGATE  = 4'd13,
        PIN_RSV14  = 4'd14,
        PIN_FIELD  = 4'd15
    } pin_sel_e;

    typedef enum logic {
        ST_BLANK  = 1'b0,
        ST_ACTIVE = 1'b1
    } line_st_e;

    typedef struct packed {
        logic [3:0] sel;
        logic       pol;
        logic [7:0] hbeg;
        logic [7:0] hend;
        logic [1:0] hfine;
        logic [8:0] vbeg;
        logic [8:0] vend;
        logic       vmid;
    } vsr_cfg_t;

endpackage

// File: rtl/vsr_timebase.sv
module vsr_timebase #(
    parameter int LINE_PIX    = 864,
    parameter int FIELD_LINES = 312,
    localparam int HW = $clog2(LINE_PIX),
    localparam int VW = $clog2(FIELD_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          fpar,
    output logic          eol,
    output logic          tog1,
    output logic          tog2
);
    logic [1:0] phase;

    assign eol  = (hcnt == HW'(LINE_PIX - 1));
    assign tog1 = phase[0];
    assign tog2 = phase[1];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hcnt  <= '0;
            vcnt  <= '0;
            fpar  <= 1'b0;
            phase <= '0;
        end else begin
            phase <= phase + 2'd1;
            if (eol) begin
                hcnt <= '0;
                if (vcnt == VW'(FIELD_LINES - 1)) begin
                    vcnt <= '0;
                    fpar <= ~fpar;
                end else begin
                    vcnt <= vcnt + VW'(1);
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end
endmodule

// File: rtl/vsr_hgen.sv
module vsr_hgen
    import vsr_pkg::*;
#(
    parameter int LINE_PIX  = 864,
    parameter int ACT_BEGIN = 132,
    parameter int ACT_PIX   = 720,
    localparam int HW = $clog2(LINE_PIX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hcnt,
    input  logic [7:0]    hbeg,
    input  logic [7:0]    hend,
    input  logic [1:0]    hfine,
    output logic          href,
    output logic          hs
);
    localparam logic [HW-1:0] OPEN_AT  = HW'(ACT_BEGIN - 1);
    localparam logic [HW-1:0] CLOSE_AT = HW'(ACT_BEGIN + ACT_PIX - 1);

    line_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= ST_BLANK;
        else     st_q <= st_d;
    end

    // transitions: open, close
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BLANK:  if (hcnt == OPEN_AT)  st_d = ST_ACTIVE;
            ST_ACTIVE: if (hcnt == CLOSE_AT) st_d = ST_BLANK;
        endcase
    end

    // outputs
    logic [31:0] b_pos, e_pos, hc;
    always_comb begin
        href  = (st_q == ST_ACTIVE);
        hc    = 32'(hcnt);
        b_pos = 32'(hbeg) * 8 + 32'(hfine) * 2;
        e_pos = 32'(hend) * 8 + 32'(hfine) * 2;
        if (b_pos < e_pos)      hs = (hc >= b_pos) && (hc < e_pos);
        else if (b_pos > e_pos) hs = (hc >= b_pos) || (hc < e_pos);
        else                    hs = 1'b0;
    end
endmodule

// File: rtl/vsr_vgen.sv
module vsr_vgen #(
    parameter int LINE_PIX    = 864,
    parameter int FIELD_LINES = 312,
    parameter int VS_LINES    = 3,
    localparam int HW = $clog2(LINE_PIX),
    localparam int VW = $clog2(FIELD_LINES)
) (
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          fpar,
    input  logic [8:0]    vbeg,
    input  logic [8:0]    vend,
    input  logic          vmid,
    output logic          vgate,
    output logic          vs,
    output logic          fid
);
    logic [31:0] vc, vprev, veff, s_ln, t_ln;

    always_comb begin
        vc    = 32'(vcnt);
        vprev = (vc == 32'd0) ? 32'(FIELD_LINES - 1) : vc - 32'd1;
        veff  = (vmid && (32'(hcnt) < 32'(LINE_PIX / 2))) ? vprev : vc;
        s_ln  = 32'(vbeg);
        t_ln  = 32'(vend);
        if (s_ln < t_ln)      vgate = (veff >= s_ln) && (veff < t_ln);
        else if (s_ln > t_ln) vgate = (veff >= s_ln) || (veff < t_ln);
        else                  vgate = 1'b0;
        vs  = (vc < 32'(VS_LINES));
        fid = fpar ^ (vc < s_ln);
    end
endmodule

// File: rtl/vsr_pinmux.sv
module vsr_pinmux
    import vsr_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       pol,
    input  logic       tog1,
    input  logic       tog2,
    input  logic       lk_h,
    input  logic       lk_v,
    input  logic       col,
    input  logic       href,
    input  logic       hs,
    input  logic       vs,
    input  logic       vgate,
    input  logic       fid,
    output logic       pin,
    output logic       oe
);
    logic sig;

    always_comb begin
        sig = 1'b0;
        unique case (pin_sel_e'(sel))
            PIN_HIZ, PIN_LOW, PIN_RSV7,
            PIN_RSV11, PIN_RSV14: sig = 1'b0;
            PIN_TOG1:   sig = tog1;
            PIN_TOG2:   sig = tog2;
            PIN_HLOCK:  sig = lk_h;
            PIN_HVLOCK: sig = lk_h & lk_v;
            PIN_ALLOK:  sig = lk_h & lk_v & col;
            PIN_HREF:   sig = href;
            PIN_HSYNC:  sig = hs;
            PIN_GATED:  sig = href & vgate;
            PIN_VSYNC:  sig = vs;
            PIN_VGATE:  sig = vgate;
            PIN_FIELD:  sig = fid;
        endcase
        oe  = (pin_sel_e'(sel) != PIN_HIZ);
        pin = oe & (sig ^ pol);
    end
endmodule

// File: rtl/vid_sync_ref.sv
module vid_sync_ref
    import vsr_pkg::*;
#(
    parameter int LINE_PIX    = 864,
    parameter int FIELD_LINES = 312,
    parameter int ACT_BEGIN   = 132,
    parameter int ACT_PIX     = 720,
    parameter int VS_LINES    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] cfg_sel,
    input  logic       cfg_pol,
    input  logic [7:0] cfg_hbeg,
    input  logic [7:0] cfg_hend,
    input  logic [1:0] cfg_hfine,
    input  logic [8:0] cfg_vbeg,
    input  logic [8:0] cfg_vend,
    input  logic       cfg_vmid,
    input  logic       lock_h,
    input  logic       lock_v,
    input  logic       color_det,
    output logic       rts_o,
    output logic       rts_oe,
    output logic       href_o,
    output logic       hs_o,
    output logic       vs_o,
    output logic       fid_o
);
    localparam int HW = $clog2(LINE_PIX);
    localparam int VW = $clog2(FIELD_LINES);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          fpar, eol, tog1, tog2;
    logic          href, hs, vs, vgate, fid;
    vsr_cfg_t      shd;
    logic [3:0]    sel_q;
    logic          pol_q;

    // shadow settings, loaded on the edge where the line wraps
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            shd <= '0;
        end else if (eol) begin
            shd.sel   <= cfg_sel;
            shd.pol   <= cfg_pol;
            shd.hbeg  <= cfg_hbeg;
            shd.hend  <= cfg_hend;
            shd.hfine <= cfg_hfine;
            shd.vbeg  <= cfg_vbeg;
            shd.vend  <= cfg_vend;
            shd.vmid  <= cfg_vmid;
        end
    end

    assign sel_q = shd.sel;
    assign pol_q = shd.pol;

    vsr_timebase #(
        .LINE_PIX(LINE_PIX), .FIELD_LINES(FIELD_LINES)
    ) u_tb (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .fpar(fpar),
        .eol(eol), .tog1(tog1), .tog2(tog2)
    );

    vsr_hgen #(
        .LINE_PIX(LINE_PIX), .ACT_BEGIN(ACT_BEGIN), .ACT_PIX(ACT_PIX)
    ) u_hg (
        .clk(clk), .rst(rst), .hcnt(hcnt), .hbeg(shd.hbeg), .hend(shd.hend),
        .hfine(shd.hfine), .href(href), .hs(hs)
    );

    vsr_vgen #(
        .LINE_PIX(LINE_PIX), .FIELD_LINES(FIELD_LINES), .VS_LINES(VS_LINES)
    ) u_vg (
        .hcnt(hcnt), .vcnt(vcnt), .fpar(fpar), .vbeg(shd.vbeg),
        .vend(shd.vend), .vmid(shd.vmid), .vgate(vgate), .vs(vs), .fid(fid)
    );

    vsr_pinmux u_pm (
        .sel(sel_q), .pol(pol_q), .tog1(tog1), .tog2(tog2),
        .lk_h(lock_h), .lk_v(lock_v), .col(color_det), .href(href),
        .hs(hs), .vs(vs), .vgate(vgate), .fid(fid), .pin(rts_o), .oe(rts_oe)
    );

    assign href_o = href;
    assign hs_o   = hs;
    assign vs_o   = vs;
    assign fid_o  = fid;
endmodule

// File: rtl/vsr_chk.sv
module vsr_chk #(
    parameter int LINE_PIX  = 864,
    parameter int ACT_BEGIN = 132,
    parameter int ACT_PIX   = 720,
    localparam int HW = $clog2(LINE_PIX)
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] hcnt,
    input logic          href,
    input logic          hs,
    input logic          tog1,
    input logic [3:0]    sel_q,
    input logic          pol_q,
    input logic          rts_o,
    input logic          rts_oe
);
    logic [31:0] run;
    always_ff @(posedge clk or posedge rst) begin
        if (rst)       run <= '0;
        else if (href) run <= run + 32'd1;
        else           run <= '0;
    end

    AST_OE_HIZ: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 4'd0) |-> (!rts_oe && !rts_o));                          // R2
    AST_TOG_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tog1 != $past(tog1)));                                    // R4
    AST_HREF_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(href) |-> (hcnt == HW'(ACT_BEGIN)));                          // R6
    AST_HREF_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(href) |-> (run == 32'(ACT_PIX)));                             // R6
    AST_HS_EVEN_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(hs) |-> !hcnt[0]);                                         // R7
    AST_GATED_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 4'd10 && rts_oe && (rts_o ^ pol_q)) |-> href);            // R10
    AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hcnt != '0) |-> ($stable(sel_q) && $stable(pol_q)));               // R14
endmodule

bind vid_sync_ref vsr_chk #(
    .LINE_PIX(LINE_PIX), .ACT_BEGIN(ACT_BEGIN), .ACT_PIX(ACT_PIX)
) u_chk (
    .clk(clk), .rst(rst), .hcnt(hcnt), .href(href), .hs(hs), .tog1(tog1),
    .sel_q(sel_q), .pol_q(pol_q), .rts_o(rts_o), .rts_oe(rts_oe)
);

// File: tb/vid_sync_ref_bench.sv
module vid_sync_ref_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LP  = 64;
    localparam int FL  = 12;
    localparam int AB  = 8;
    localparam int AP  = 40;
    localparam int VSL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] cfg_sel = '0;
    logic       cfg_pol = 1'b0;
    logic [7:0] cfg_hbeg = '0, cfg_hend = '0;
    logic [1:0] cfg_hfine = '0;
    logic [8:0] cfg_vbeg = '0, cfg_vend = '0;
    logic       cfg_vmid = 1'b0;
    logic       lock_h = 1'b0, lock_v = 1'b0, color_det = 1'b0;
    logic rts_o, rts_oe, href_o, hs_o, vs_o, fid_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_sync_ref #(
        .LINE_PIX(LP), .FIELD_LINES(FL), .ACT_BEGIN(AB), .ACT_PIX(AP), .VS_LINES(VSL)
    ) u_vid_sync_ref (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_pol(cfg_pol),
        .cfg_hbeg(cfg_hbeg), .cfg_hend(cfg_hend), .cfg_hfine(cfg_hfine),
        .cfg_vbeg(cfg_vbeg), .cfg_vend(cfg_vend), .cfg_vmid(cfg_vmid),
        .lock_h(lock_h), .lock_v(lock_v), .color_det(color_det),
        .rts_o(rts_o), .rts_oe(rts_oe), .href_o(href_o), .hs_o(hs_o),
        .vs_o(vs_o), .fid_o(fid_o)
    );

    int k = 0;
    int vec = 0;
    int fails = 0;
    string ovr = "";

    always @(posedge clk) if (!rst) k <= k + 1;

    // settings the design is expected to be using
    int a_sel = 0, a_pol = 0, a_hb = 0, a_he = 0, a_hf = 0, a_vb = 0, a_ve = 0, a_vm = 0;

    function automatic string tag_of(int s);
        case (s)
            0: return "R2";
            1, 7, 11, 14: return "R3";
            2, 3: return "R4";
            4, 5, 6: return "R5";
            8: return "R6";
            9: return "R7";
            10: return "R10";
            12: return "R11";
            13: return (a_vm != 0) ? "R9" : "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic int win(int x, int b, int e);
        if (b < e) return (x >= b && x < e) ? 1 : 0;
        if (b > e) return (x >= b || x < e) ? 1 : 0;
        return 0;
    endfunction

    task automatic chk(string tg, int got, int exp, string what);
        vec++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s k=%0d sel=%0d got=%0d exp=%0d", tg, what, k, a_sel, got, exp);
        end
    endtask

    // one cycle: sample at the falling edge, compare with the arithmetic model
    task automatic step();
        int h, ln, v, fp, hr, hs, ve, vg, vs, fd, sg, eo, ep;
        @(negedge clk);
        if (k > 0 && (k % LP) == 0) begin   // R14: settings apply from the wrap
            a_sel = cfg_sel; a_pol = cfg_pol; a_hb = cfg_hbeg; a_he = cfg_hend;
            a_hf = cfg_hfine; a_vb = cfg_vbeg; a_ve = cfg_vend; a_vm = cfg_vmid;
        end
        h  = k % LP;
        ln = k / LP;
        v  = ln % FL;
        fp = (ln / FL) % 2;
        hr = (h >= AB && h < AB + AP) ? 1 : 0;
        hs = win(h, a_hb * 8 + a_hf * 2, a_he * 8 + a_hf * 2);
        ve = (a_vm != 0 && h < LP / 2) ? ((v == 0) ? FL - 1 : v - 1) : v;
        vg = win(ve, a_vb, a_ve);
        vs = (v < VSL) ? 1 : 0;
        fd = fp ^ ((v < a_vb) ? 1 : 0);
        case (a_sel)
            2: sg = k % 2;
            3: sg = (k / 2) % 2;
            4: sg = lock_h;
            5: sg = lock_h & lock_v;
            6: sg = lock_h & lock_v & color_det;
            8: sg = hr;
            9: sg = hs;
            10: sg = hr & vg;
            12: sg = vs;
            13: sg = vg;
            15: sg = fd;
            default: sg = 0;
        endcase
        eo = (a_sel != 0) ? 1 : 0;
        ep = eo ? (sg ^ a_pol) : 0;           // R13 inversion
        chk((ovr != "") ? ovr : tag_of(a_sel), {30'd0, rts_oe, rts_o}, eo * 2 + ep, "pin{oe,o}");
        chk("R6",  int'(href_o), hr, "href_o");
        chk("R7",  int'(hs_o),   hs, "hs_o");
        chk("R11", int'(vs_o),   vs, "vs_o");
        chk("R12", int'(fid_o),  fd, "fid_o");
        lock_h    = ((k >> 2) & 1) == 1;      // R5 live flags
        lock_v    = ((k >> 3) & 1) == 1;
        color_det = ((k >> 4) & 1) == 1;
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    task automatic to_wrap();
        do step(); while ((k % LP) != 0);
    endtask

    task automatic setcfg(int s, int p, int hb, int he, int hf, int vb, int ve, int vm);
        cfg_sel = 4'(s); cfg_pol = 1'(p); cfg_hbeg = 8'(hb); cfg_hend = 8'(he);
        cfg_hfine = 2'(hf); cfg_vbeg = 9'(vb); cfg_vend = 9'(ve); cfg_vmid = 1'(vm);
    endtask

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", {27'd0, rts_oe, rts_o, href_o, hs_o, fid_o}, 0, "reset outs");
        end
        rst = 1'b0;
        run(2 * LP);                           // R2 default code 0 after reset

        // R2 R3 R4 R5 R6 R13: every code in both polarities
        for (int s = 0; s < 16; s++)
            for (int p = 0; p < 2; p++) begin
                setcfg(s, p, 2, 5, 1, 2, 5, 0);
                to_wrap();
                run(LP);
            end

        // R7 horizontal sync edges: plain, shifted, wrapped, empty, off-line
        begin
            int hv[7][3] = '{'{1,4,0}, '{1,4,3}, '{6,2,1}, '{3,3,2}, '{0,7,3}, '{7,0,0}, '{20,30,0}};
            for (int i = 0; i < 7; i++) begin
                setcfg(9, i % 2, hv[i][0], hv[i][1], hv[i][2], 0, 0, 0);
                to_wrap();
                run(LP);
            end
        end

        // R8 R9 R10 vertical gate incl. wrap, empty and mid-line switch
        begin
            int vv[5][2] = '{'{2,5}, '{9,3}, '{4,4}, '{0,12}, '{11,0}};
            for (int m = 0; m < 2; m++)
                for (int i = 0; i < 5; i++) begin
                    setcfg(13, 0, 0, 0, 0, vv[i][0], vv[i][1], m);
                    to_wrap();
                    run(FL * LP);
                end
            setcfg(10, 0, 0, 0, 0, 2, 7, 1);
            to_wrap();
            run(FL * LP);
        end

        // R11 vertical sync over a field
        setcfg(12, 1, 0, 0, 0, 0, 0, 0);
        to_wrap();
        run(FL * LP);

        // R12 field identifier over two fields per start line
        begin
            int fv[4] = '{0, 3, 11, 20};
            for (int i = 0; i < 4; i++) begin
                setcfg(15, 0, 0, 0, 0, fv[i], 0, 0);
                to_wrap();
                run(2 * FL * LP);
            end
        end

        // R14 mid-line change holds until the wrap
        setcfg(8, 0, 1, 4, 0, 0, 0, 0);
        to_wrap();
        run(20);
        ovr = "R14";
        setcfg(9, 1, 2, 3, 1, 0, 0, 0);
        to_wrap();
        ovr = "";
        run(LP);
        run(20);
        ovr = "R14";
        setcfg(0, 1, 0, 0, 0, 0, 0, 0);
        to_wrap();
        ovr = "";
        run(LP);

        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired at k=%0d exp=finish", k);
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end
endmodule